// File: doc/BRIEF.md
# Byte Block Copy Sequencer

This block moves a run of bytes from one region of a 16-bit address space to another through a single byte-wide memory port. A caller gives it a source address, a destination address, a byte count and a 3-bit stepping mode, then pulses `start`. The block handles one byte at a time. It issues a read at the current source address and waits until the memory returns valid data. It then writes that byte to the current destination address and waits for the acknowledge. After the acknowledge, both addresses step as the mode selects.

The modes cover linear copies that go upward or downward. They also cover writes that stay on one fixed address, and patterns in which one side moves between a base address and the address just above it. The fixed and alternating patterns suit byte-wide ports that sit behind one or two register addresses. `busy` is high for the whole transfer. `done` pulses once after the last byte is written.

Top module: `bytemove_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `rd_req` and `wr_req` are all low.
- R2: Each byte is one read followed by one write, and the two requests are never high together. `rd_req` stays high with a stable `rd_addr` until `rd_valid` arrives. `wr_req` then stays high with stable `wr_addr` and `wr_data` until `wr_ack`. The byte written is the byte returned by the read just before it.
- R3: Mode code 0 steps the source up by one and the destination up by one after each byte.
- R4: Mode code 1 steps the source down by one and the destination down by one after each byte.
- R5: Mode code 2 steps the source up by one after each byte. The destination keeps its start value for the whole transfer.
- R6: Mode code 3 steps the source up by one after each byte. The destination uses its base address on even bytes (0, 2, 4, …) and base+1 on odd bytes.
- R7: Mode code 4 uses the source base address on even bytes and source base+1 on odd bytes. The destination steps up by one after each byte.
- R8: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R9: All address arithmetic is 16-bit. It wraps from 0xFFFF to 0x0000 when stepping up and from 0x0000 to 0xFFFF when stepping down.
- R10: A length of N from 1 to 65535 moves exactly N bytes. A length of 0 moves 65536 bytes.
- R11: `busy` goes high in the cycle after an accepted `start`. `done` is high for exactly one cycle, the cycle after the final `wr_ack` is taken. `busy` is low in that cycle.
- R12: A `start` pulse while `busy` is high does not change the running transfer's addresses, mode or length, and it does not start another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| src_base | input | 16 | First source address |
| dst_base | input | 16 | First destination address |
| length | input | 16 | Byte count, 0 meaning 65536 |
| mode | input | 3 | Stepping mode code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| wr_ack | input | 1 | Write acknowledge |

## Verification
The assertions check the handshake rules on every cycle: read and write never overlap, and each request holds its address and data until the response arrives. They also check that `done` is a single-cycle pulse that follows a write acknowledge, that a fixed destination never moves, and that an alternating side never leaves its base/base+1 pair. They also check that a start while busy leaves the latched mode unchanged. Only the bench scenarios show that each mode produces the right address sequence over a whole transfer, including wraparound. They also show that the written bytes match the source, that the byte count matches the length (including the 65536-byte case), and that the engine works under different memory response delays.

// File: rtl/bytemove_pkg.sv
`timescale 1ns/1ps
package bytemove_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        STEP_UP     = 2'd0,
        STEP_DOWN   = 2'd1,
        STEP_HOLD   = 2'd2,
        STEP_TOGGLE = 2'd3
    } step_kind_e;

    typedef struct packed {
        step_kind_e src;
        step_kind_e dst;
    } step_pair_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

    // Mode code to per-side stepping; codes 5..7 fall back to code 0
    function automatic step_pair_t decode_mode(input logic [MODE_W-1:0] code);
        step_pair_t p;
        case (code)
            3'd1:    p = '{src: STEP_DOWN,   dst: STEP_DOWN};
            3'd2:    p = '{src: STEP_UP,     dst: STEP_HOLD};
            3'd3:    p = '{src: STEP_UP,     dst: STEP_TOGGLE};
            3'd4:    p = '{src: STEP_TOGGLE, dst: STEP_UP};
            default: p = '{src: STEP_UP,     dst: STEP_UP};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bytemove_addr_unit.sv
`timescale 1ns/1ps
module bytemove_addr_unit
    import bytemove_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          advance,
    input  step_kind_e    kind,
    input  logic          phase,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] addr_nx;

    always_comb begin
        unique case (kind)
            STEP_UP:     addr_nx = addr_q + ONE;
            STEP_DOWN:   addr_nx = addr_q - ONE;
            STEP_HOLD:   addr_nx = addr_q;
            STEP_TOGGLE: addr_nx = phase ? (addr_q - ONE) : (addr_q + ONE);
            default:     addr_nx = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            base_q <= '0;
        end else if (load) begin
            addr_q <= base_in;
            base_q <= base_in;
        end else if (advance) begin
            addr_q <= addr_nx;
        end
    end

    assign addr = addr_q;

    AST_HOLD_FIXED: assert property (@(posedge clk) disable iff (rst)
        (advance && kind == STEP_HOLD) |=> $stable(addr)); // R5

    AST_TOGGLE_SPAN: assert property (@(posedge clk) disable iff (rst)
        (kind == STEP_TOGGLE && !load) |-> ((addr - base_q) <= ONE)); // R6

endmodule

// File: rtl/bytemove_counter.sv
`timescale 1ns/1ps
module bytemove_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len_in,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // A length of zero wraps through all values, giving 2**CW bytes
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= len_in;
        else if (dec)  cnt_q <= cnt_q - CW'(1);
    end

    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/bytemove_ctrl.sv
`timescale 1ns/1ps
module bytemove_ctrl
    import bytemove_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd_valid,
    input  logic wr_ack,
    input  logic last,
    output logic rd_req,
    output logic wr_req,
    output logic load,
    output logic capture,
    output logic advance,
    output logic phase,
    output logic busy,
    output logic done
);
    xfer_state_e state_q, state_nx;
    logic        phase_q;
    logic        done_q;

    always_comb begin
        load    = (state_q == ST_IDLE)  && start;
        capture = (state_q == ST_READ)  && rd_valid;
        advance = (state_q == ST_WRITE) && wr_ack;
        rd_req  = (state_q == ST_READ);
        wr_req  = (state_q == ST_WRITE);
        busy    = (state_q != ST_IDLE);
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_nx = ST_READ;
            ST_READ:  if (rd_valid) state_nx = ST_WRITE;
            ST_WRITE: if (wr_ack)   state_nx = last ? ST_IDLE : ST_READ;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            done_q  <= advance && last;
            if (load)         phase_q <= 1'b0;
            else if (advance) phase_q <= ~phase_q;
        end
    end

    assign phase = phase_q;
    assign done  = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_req && wr_ack) && !busy)); // R11

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R11

endmodule

// File: rtl/bytemove_engine.sv
`timescale 1ns/1ps
module bytemove_engine
    import bytemove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ADDR_W-1:0] length,
    input  logic [MODE_W-1:0] mode,
    output logic              busy,
    output logic              done,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack
);
    logic              load, capture, advance, phase, last;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] data_q;
    step_pair_t        steps;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            data_q <= '0;
        end else begin
            if (load)    mode_q <= mode;
            if (capture) data_q <= rd_data;
        end
    end

    assign steps = decode_mode(mode_q);

    bytemove_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rd_valid (rd_valid),
        .wr_ack   (wr_ack),
        .last     (last),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .load     (load),
        .capture  (capture),
        .advance  (advance),
        .phase    (phase),
        .busy     (busy),
        .done     (done)
    );

    bytemove_counter #(.CW(ADDR_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .len_in (length),
        .dec    (advance),
        .last   (last)
    );

    bytemove_addr_unit #(.AW(ADDR_W)) u_src (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .base_in (src_base),
        .advance (advance),
        .kind    (steps.src),
        .phase   (phase),
        .addr    (rd_addr)
    );

    bytemove_addr_unit #(.AW(ADDR_W)) u_dst (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .base_in (dst_base),
        .advance (advance),
        .kind    (steps.dst),
        .phase   (phase),
        .addr    (wr_addr)
    );

    assign wr_data = data_q;

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req)); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R2

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R2

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mode_q)); // R12

endmodule

// File: tb/test_bytemove_engine.sv
`timescale 1ns/1ps
module test_bytemove_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] src_base, dst_base, length;
    logic [2:0]  mode;
    logic        busy, done, rd_req, wr_req;
    logic [15:0] rd_addr, wr_addr;
    logic        rd_valid, wr_ack;
    logic [7:0]  rd_data, wr_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    // reference model state
    logic [2:0]  cur_mode;
    logic [15:0] sbase, dbase, cur_src;
    int idx, nwr, stall, wait_rd, wait_wr;
    int addr_bad, data_bad, done_cnt, busy_bad;

    always #2.5 clk = ~clk; // 200 MHz

    bytemove_engine i_bytemove_engine (
        .clk(clk), .rst(rst), .start(start),
        .src_base(src_base), .dst_base(dst_base), .length(length), .mode(mode),
        .busy(busy), .done(done),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
    );

    function automatic logic [7:0] memfn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Expected address of byte number n on one side, from the requirement text
    function automatic logic [15:0] exp_addr(input logic [2:0] m, input bit is_src,
                                             input logic [15:0] base, input int n);
        logic [15:0] nn;
        logic [2:0]  mm;
        nn = 16'(n);
        mm = (m > 3'd4) ? 3'd0 : m;
        case (mm)
            3'd1:    return base - nn;
            3'd2:    return is_src ? base + nn : base;
            3'd3:    return is_src ? base + nn : base + {15'd0, nn[0]};
            3'd4:    return is_src ? base + {15'd0, nn[0]} : base + nn;
            default: return base + nn;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // memory model: drives responses and checks traffic at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            rd_valid = 1'b0; wr_ack = 1'b0; wait_rd = 0; wait_wr = 0;
        end else begin
            if (rd_valid) rd_valid = 1'b0;
            else if (rd_req) begin
                if (wait_rd >= stall) begin
                    wait_rd  = 0;
                    rd_valid = 1'b1;
                    rd_data  = memfn(rd_addr);
                    cur_src  = exp_addr(cur_mode, 1'b1, sbase, idx);
                    if (rd_addr !== cur_src) addr_bad++;
                end else wait_rd++;
            end
            if (wr_ack) wr_ack = 1'b0;
            else if (wr_req) begin
                if (wait_wr >= stall) begin
                    wait_wr = 0;
                    wr_ack  = 1'b1;
                    if (wr_addr !== exp_addr(cur_mode, 1'b0, dbase, idx)) addr_bad++;
                    if (wr_data !== memfn(cur_src)) data_bad++;
                    idx++;
                    nwr++;
                end else wait_wr++;
            end
            if (done) begin
                done_cnt++;
                if (busy) busy_bad++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 195000);
            summary();
        end
    end

    task automatic run_xfer(input logic [2:0] m, input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] l, input int st, input bit poke);
        int expect_len;
        cur_mode = m; sbase = s; dbase = d; idx = 0; nwr = 0; stall = st;
        addr_bad = 0; data_bad = 0; done_cnt = 0; busy_bad = 0;
        mode = m; src_base = s; dst_base = d; length = l;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R11", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            mode = 3'd1; src_base = 16'hBEEF; dst_base = 16'h0F00; length = 16'd2;
            start = 1'b1; // R12: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        expect_len = (l == 16'd0) ? 65536 : int'(l);
        check(addr_bad == 0, mode_tag(m), "address mismatches", addr_bad, 0);
        check(data_bad == 0, "R2", "data mismatches", data_bad, 0);
        check(nwr == expect_len, "R10", "bytes written", nwr, expect_len);
        check(done_cnt == 1, "R11", "done cycles", done_cnt, 1);
        check(busy_bad == 0, "R11", "busy high with done", busy_bad, 0);
        check(busy === 1'b0, poke ? "R12" : "R11", "idle after done", int'(busy), 0);
    endtask

    // {mode, src, dst, len}
    localparam logic [50:0] VEC [0:8] = '{
        {3'd0, 16'h1000, 16'h2000, 16'd5},  // R3
        {3'd1, 16'h3004, 16'h4008, 16'd4},  // R4
        {3'd2, 16'h5000, 16'h6000, 16'd6},  // R5
        {3'd3, 16'h7000, 16'h8000, 16'd5},  // R6
        {3'd4, 16'h9000, 16'hA000, 16'd5},  // R7
        {3'd6, 16'h0100, 16'h0200, 16'd3},  // R8
        {3'd0, 16'hFFFE, 16'hFFFF, 16'd4},  // R9 upward wrap
        {3'd1, 16'h0001, 16'h0000, 16'd3},  // R9 downward wrap
        {3'd3, 16'h0010, 16'hFFFF, 16'd4}   // R9 alternate across wrap
    };

    initial begin
        rst = 1'b1; start = 1'b0; mode = '0; src_base = '0; dst_base = '0; length = '0;
        stall = 0; cur_mode = '0; sbase = '0; dbase = '0; cur_src = '0; idx = 0;
        rd_valid = 1'b0; wr_ack = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_req && !wr_req, "R1", "outputs in reset",
              int'({busy, done, rd_req, wr_req}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rd_req && !wr_req, "R1", "outputs after reset",
              int'({busy, done, rd_req, wr_req}), 0);

        for (int i = 0; i < 9; i++) begin
            run_xfer(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], i % 3, 1'b0);
        end

        // R12: start pulse during a running transfer
        run_xfer(3'd0, 16'h2200, 16'h3300, 16'd6, 2, 1'b1);
        // R10: single byte
        run_xfer(3'd4, 16'h4400, 16'h5500, 16'd1, 1, 1'b0);
        // R10: zero length means 65536 bytes
        run_xfer(3'd2, 16'h0000, 16'h7777, 16'd0, 0, 1'b0);

        summary();
    end

endmodule